// File: doc/BRIEF.md
# NOR Flash Erase Controller with Suspend

This controller drives the write and read strobes of a byte-wide NOR flash to erase either one sector or the whole device. A host gives it single-cycle commands: erase a sector, erase the chip, suspend, resume, and a program request. It then emits the unlock-and-confirm write cycles, waits half of the typical erase time, and polls for completion by reading the device twice in a row until the two reads agree.

While an erase is running, the host may suspend it so that the array can be read. The controller keeps the address the erase was issued to, because the suspend and resume commands go to that address. A suspend that does not settle within its own timeout is backed out by resuming the erase, and a sticky flag records the failure. Every resume restarts the long erase timeout. If that timeout expires, a reset cycle is written to the device base and an error is reported. A program request is refused while the erase is suspended. Status is reported as six one-hot bits.

Top module: `nor_erase_ctrl`

## Requirements
- R1: A sector erase command (cmd_op=1) produces six single-cycle writes on consecutive cycles: 0xAA@U1, 0x55@U2, 0x80@U1, 0xAA@U1, 0x55@U2, then 0x30 to cmd_addr. U1=0x555 and U2=0x2AA.
- R2: A chip erase command (cmd_op=2) produces the same five-write prefix, then 0x10@U1. U1 becomes the stored erase address.
- R3: After the final erase write there are exactly HALF=ERASE_TYP_CYC/2 cycles with no bus activity. The first read strobe therefore comes HALF+1 cycles after the final write.
- R4: Polling issues two reads of the stored address. Completion is declared when the second read returns the same byte as the first. Status then moves from erasing (bit1) to done (bit4).
- R5: A suspend command (cmd_op=3) during the wait or polling phase writes 0xB0 to the stored erase address and enters suspending (bit2). When two successive reads match, it enters suspended (bit3).
- R6: If a suspend has not settled within SUS_TMO_CYC cycles, the controller writes 0x30 to the stored address, sets sus_fail, and returns to erasing. sus_fail stays set until the next erase is accepted.
- R7: A resume command (cmd_op=4) while suspended writes 0x30 to the stored address and returns to erasing.
- R8: The erase timeout counts ERASE_TMO_CYC cycles from the final erase write and restarts on every resume write. On expiry, the controller writes 0xF0 to BASE_ADDR and enters error (bit5).
- R9: A program request (cmd_op=5) while suspended raises prog_reject in the same cycle. It causes no bus write and leaves the state suspended.
- R10: After reset, status is 6'b000001 (idle). status always has exactly one bit set.
- R11: Commands that do not fit the current state cause no bus cycle and no state change. Examples are a suspend while idle and an erase while an erase is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 3 | 1 sector erase, 2 chip erase, 3 suspend, 4 resume, 5 program request |
| cmd_addr | input | AW | Sector address for sector erase |
| bus_we | output | 1 | Flash write cycle strobe |
| bus_re | output | 1 | Flash read cycle strobe |
| bus_addr | output | AW | Flash address |
| bus_wdata | output | 8 | Flash write data |
| bus_rdata | input | 8 | Flash read data, valid the cycle after bus_re |
| status | output | 6 | One-hot: idle, erasing, suspending, suspended, done, error |
| sus_fail | output | 1 | Sticky: a suspend did not settle and was backed out |
| prog_reject | output | 1 | Program request refused while suspended |

## Verification
The assertions assume three things about the inputs:
- commands last exactly one cycle;
- the device returns read data registered one cycle after each read strobe;
- the device changes that data only on read strobes.

The bench models the device as a registered responder with these properties. Its status bit toggles on each read while an erase or an unsettled suspend is in progress. It issues commands on falling edges, one cycle each, so every assumption holds for the whole run.

// File: rtl/nor_erase_ctrl.sv
module nor_erase_ctrl #(
  parameter int AW = 12,
  parameter logic [AW-1:0] U1 = 12'h555,
  parameter logic [AW-1:0] U2 = 12'h2AA,
  parameter logic [AW-1:0] BASE_ADDR = '0,
  parameter int ERASE_TYP_CYC = 2000,
  parameter int ERASE_TMO_CYC = 80000,
  parameter int SUS_TMO_CYC = 200,
  parameter int TW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  output logic          bus_we,
  output logic          bus_re,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  input  logic [7:0]    bus_rdata,
  output logic [5:0]    status,
  output logic          sus_fail,
  output logic          prog_reject
);
  localparam int HALF = ERASE_TYP_CYC / 2;

  typedef enum logic [3:0] {
    S_IDLE, S_SEQ, S_WAIT, S_POLL, S_SUSW, S_SPOLL, S_SUSP, S_RESW, S_RSTW, S_DONE, S_ERR
  } st_t;

  st_t st;
  logic [2:0] idx;
  logic [1:0] ph;
  logic [TW-1:0] tmr, etmr;
  logic [AW-1:0] ers_addr;
  logic chip_mode;
  logic [7:0] d1;

  wire erase_req = cmd_valid && (cmd_op == 3'd1 || cmd_op == 3'd2) &&
                   (st == S_IDLE || st == S_DONE || st == S_ERR);
  wire sus_req   = cmd_valid && cmd_op == 3'd3 && (st == S_WAIT || st == S_POLL);
  wire res_req   = cmd_valid && cmd_op == 3'd4 && st == S_SUSP;
  wire settled   = (ph == 2'd2) && (d1 == bus_rdata);
  wire etmo_hit  = etmr >= TW'(ERASE_TMO_CYC - 1);
  wire [1:0] ph_nx = (ph == 2'd2) ? 2'd0 : ph + 2'd1;

  assign prog_reject = cmd_valid && cmd_op == 3'd5 && st == S_SUSP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; ph <= '0; tmr <= '0; etmr <= '0;
      ers_addr <= '0; chip_mode <= 1'b0; d1 <= '0; sus_fail <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_DONE, S_ERR: if (erase_req) begin
          st <= S_SEQ; idx <= '0; etmr <= '0; sus_fail <= 1'b0;
          chip_mode <= (cmd_op == 3'd2);
          ers_addr  <= (cmd_op == 3'd2) ? U1 : cmd_addr;
        end
        S_SEQ: begin
          idx <= idx + 3'd1;
          if (idx == 3'd5) begin st <= S_WAIT; tmr <= '0; end
        end
        S_WAIT: begin
          tmr <= tmr + 1'b1; etmr <= etmr + 1'b1;
          if (sus_req) st <= S_SUSW;
          else if (tmr == TW'(HALF - 1)) begin st <= S_POLL; ph <= '0; end
        end
        S_POLL: begin
          etmr <= etmr + 1'b1; ph <= ph_nx;
          if (ph == 2'd1) d1 <= bus_rdata;
          if (sus_req) st <= S_SUSW;
          else if (settled) st <= S_DONE;
          else if (etmo_hit) st <= S_RSTW;
        end
        S_SUSW: begin st <= S_SPOLL; ph <= '0; tmr <= '0; end
        S_SPOLL: begin
          tmr <= tmr + 1'b1; ph <= ph_nx;
          if (ph == 2'd1) d1 <= bus_rdata;
          if (settled) st <= S_SUSP;
          else if (tmr == TW'(SUS_TMO_CYC - 1)) begin st <= S_RESW; sus_fail <= 1'b1; end
        end
        S_SUSP: if (res_req) st <= S_RESW;
        S_RESW: begin st <= S_POLL; ph <= '0; etmr <= '0; end
        S_RSTW: st <= S_ERR;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_we = 1'b0; bus_re = 1'b0; bus_addr = '0; bus_wdata = '0;
    case (st)
      S_SEQ: begin
        bus_we = 1'b1;
        case (idx)
          3'd0: begin bus_addr = U1; bus_wdata = 8'hAA; end
          3'd1: begin bus_addr = U2; bus_wdata = 8'h55; end
          3'd2: begin bus_addr = U1; bus_wdata = 8'h80; end
          3'd3: begin bus_addr = U1; bus_wdata = 8'hAA; end
          3'd4: begin bus_addr = U2; bus_wdata = 8'h55; end
          default: begin bus_addr = ers_addr; bus_wdata = chip_mode ? 8'h10 : 8'h30; end
        endcase
      end
      S_POLL, S_SPOLL: begin bus_re = (ph != 2'd2); bus_addr = ers_addr; end
      S_SUSW: begin bus_we = 1'b1; bus_addr = ers_addr;  bus_wdata = 8'hB0; end
      S_RESW: begin bus_we = 1'b1; bus_addr = ers_addr;  bus_wdata = 8'h30; end
      S_RSTW: begin bus_we = 1'b1; bus_addr = BASE_ADDR; bus_wdata = 8'hF0; end
      default: ;
    endcase
  end

  always_comb begin
    case (st)
      S_IDLE:                                status = 6'b000001;
      S_SEQ, S_WAIT, S_POLL, S_RESW, S_RSTW: status = 6'b000010;
      S_SUSW, S_SPOLL:                       status = 6'b000100;
      S_SUSP:                                status = 6'b001000;
      S_DONE:                                status = 6'b010000;
      default:                               status = 6'b100000;
    endcase
  end

  assert_status_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(status) == 1);
  assert_suspend_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> bus_we && bus_wdata == 8'hB0 && bus_addr == ers_addr);
  assert_abort_resumes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sus_fail) |-> bus_we && bus_wdata == 8'h30 && bus_addr == ers_addr);
  assert_timeout_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_wdata == 8'hF0 |=> status[5]);
  assert_done_from_erasing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[4]) |-> $past(status[1]));
endmodule

// File: tb/nor_erase_ctrl_bench.sv
module nor_erase_ctrl_bench;
  localparam int AW = 12;
  localparam int TYP = 20;
  localparam int HALF = TYP / 2;
  localparam int ETMO = 400;
  localparam int STMO = 30;
  localparam int SETTLE = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic bus_we, bus_re, sus_fail, prog_reject;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata = 8'hFF;
  logic [5:0] status;

  always #5 clk = ~clk;

  nor_erase_ctrl #(.AW(AW), .ERASE_TYP_CYC(TYP), .ERASE_TMO_CYC(ETMO),
                   .SUS_TMO_CYC(STMO), .TW(16)) u_nor_erase_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .status(status), .sus_fail(sus_fail), .prog_reject(prog_reject));

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // device model
  bit m_busy = 0, m_sus = 0, never_settle = 0, never_done = 0, tog = 0;
  int m_cnt = 0, m_scnt = 0, m_len = 40;

  always @(posedge clk) begin
    if (bus_we) begin
      case (bus_wdata)
        8'h10: begin m_busy <= 1; m_cnt <= m_len; end
        8'h30: if (m_sus) m_sus <= 0; else begin m_busy <= 1; m_cnt <= m_len; end
        8'hB0: if (m_busy) begin m_sus <= 1; m_scnt <= SETTLE; end
        8'hF0: begin m_busy <= 0; m_sus <= 0; end
        default: ;
      endcase
    end else if (m_busy && !m_sus && !never_done) begin
      if (m_cnt == 0) m_busy <= 0; else m_cnt <= m_cnt - 1;
    end
    if (m_sus && m_scnt > 0 && !never_settle) m_scnt <= m_scnt - 1;
    if (bus_re) begin
      if (m_busy && !(m_sus && m_scnt == 0)) begin
        tog <= ~tog;
        bus_rdata <= {1'b0, tog, 6'h0};
      end else bus_rdata <= m_busy ? 8'h80 : 8'hFF;
    end
  end

  // scoreboard
  logic [AW+7:0] q[$];
  int cyc = 0, last_w = 0;
  bit arm_gap = 0, wait_gap = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_w(input logic [AW-1:0] a, input logic [7:0] d);
    q.push_back({a, d});
  endtask

  task automatic expect_prefix();
    expect_w(12'h555, 8'hAA); expect_w(12'h2AA, 8'h55); expect_w(12'h555, 8'h80);
    expect_w(12'h555, 8'hAA); expect_w(12'h2AA, 8'h55);
  endtask

  always @(negedge clk) begin
    if (rst_n && bus_we) begin
      if (q.size() == 0) chk(1'b0, "R11 unexpected bus write", {bus_addr, bus_wdata}, 0);
      else begin
        logic [AW+7:0] e;
        e = q.pop_front();
        chk({bus_addr, bus_wdata} == e, "R1/R2/R5/R6/R7/R8 write sequence", {bus_addr, bus_wdata}, e);
      end
      if (arm_gap && (bus_wdata == 8'h30 || bus_wdata == 8'h10)) begin
        last_w = cyc; wait_gap = 1; arm_gap = 0;
      end
    end
    if (rst_n && bus_re && wait_gap) begin
      wait_gap = 0;
      chk(cyc - last_w == HALF + 1, "R3 wait before first poll", cyc - last_w, HALF + 1);
    end
  end

  task automatic issue(input logic [2:0] op, input logic [AW-1:0] a, output bit rej);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
    #1 rej = prog_reject;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = '0;
  endtask

  task automatic wait_bit(input int b, input int maxc, input string tag);
    int n = 0;
    while (!status[b] && n < maxc) begin @(negedge clk); n++; end
    chk(status[b], tag, status, 1 << b);
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    bit rej;
    repeat (3) @(negedge clk);
    chk(status == 6'b000001, "R10 reset status idle", status, 1);
    chk(bus_we == 0 && bus_re == 0, "R10 reset bus quiet", {bus_we, bus_re}, 0);
    rst_n = 1'b1;
    idle_cycles(2);

    issue(3'd3, 12'h000, rej);
    idle_cycles(5);
    chk(status == 6'b000001, "R11 suspend while idle ignored", status, 1);

    m_len = 40;
    expect_prefix(); expect_w(12'h7C0, 8'h30);
    arm_gap = 1;
    issue(3'd1, 12'h7C0, rej);
    idle_cycles(3);
    chk(status == 6'b000010, "R1 erasing after sector command", status, 2);
    wait_bit(4, 200, "R4 sector erase completes");
    chk(q.size() == 0, "R1 all sector writes seen", q.size(), 0);

    expect_prefix(); expect_w(12'h555, 8'h10);
    arm_gap = 1;
    issue(3'd2, 12'h123, rej);
    idle_cycles(4);
    issue(3'd1, 12'h444, rej);
    chk(status == 6'b000010, "R11 erase during erase ignored", status, 2);
    wait_bit(4, 200, "R2 chip erase completes");
    chk(q.size() == 0, "R2 all chip writes seen", q.size(), 0);

    m_len = 200;
    expect_prefix(); expect_w(12'h3A0, 8'h30);
    issue(3'd1, 12'h3A0, rej);
    idle_cycles(30);
    expect_w(12'h3A0, 8'hB0);
    issue(3'd3, 12'h000, rej);
    chk(status == 6'b000100, "R5 suspending after suspend command", status, 4);
    wait_bit(3, 60, "R5 suspend settles");
    chk(sus_fail == 0, "R5 no suspend failure", sus_fail, 0);
    issue(3'd5, 12'h3A0, rej);
    chk(rej == 1, "R9 program refused while suspended", rej, 1);
    idle_cycles(5);
    chk(status == 6'b001000, "R9 still suspended after program request", status, 8);
    expect_w(12'h3A0, 8'h30);
    issue(3'd4, 12'h000, rej);
    chk(status == 6'b000010, "R7 erasing after resume", status, 2);
    wait_bit(4, 400, "R7 resumed erase completes");

    m_len = 100; never_settle = 1;
    expect_prefix(); expect_w(12'h150, 8'h30);
    issue(3'd1, 12'h150, rej);
    idle_cycles(30);
    expect_w(12'h150, 8'hB0); expect_w(12'h150, 8'h30);
    issue(3'd3, 12'h000, rej);
    begin
      int n = 0;
      while (!sus_fail && n < 100) begin @(negedge clk); n++; end
    end
    chk(sus_fail == 1, "R6 suspend failure flagged", sus_fail, 1);
    @(negedge clk);
    chk(status == 6'b000010, "R6 back to erasing", status, 2);
    never_settle = 0;
    wait_bit(4, 300, "R6 erase completes after abort");
    chk(sus_fail == 1, "R6 failure flag sticky", sus_fail, 1);

    m_len = 600;
    expect_prefix(); expect_w(12'h080, 8'h30);
    issue(3'd1, 12'h080, rej);
    chk(sus_fail == 0, "R6 flag cleared by new erase", sus_fail, 0);
    idle_cycles(300);
    expect_w(12'h080, 8'hB0);
    issue(3'd3, 12'h000, rej);
    wait_bit(3, 60, "R5 suspend settles late in erase");
    expect_w(12'h080, 8'h30);
    issue(3'd4, 12'h000, rej);
    wait_bit(4, 500, "R8 timeout restarted by resume");
    chk(status[5] == 0, "R8 no error after resume restart", status, 16);

    never_done = 1; m_len = 40;
    expect_prefix(); expect_w(12'h0F0, 8'h30); expect_w(12'h000, 8'hF0);
    issue(3'd1, 12'h0F0, rej);
    idle_cycles(ETMO - 30);
    chk(status == 6'b000010, "R8 still erasing before timeout", status, 2);
    wait_bit(5, 100, "R8 timeout gives error");
    never_done = 0;
    idle_cycles(3);
    chk(q.size() == 0, "R8 all writes seen", q.size(), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule